// File: doc/BRIEF.md
# Two-Alarm Time Comparator with Interrupt Steering

This block keeps two independent alarm settings next to a real-time clock. Each setting has four bytes: seconds, minutes, hours and day of week. On every one-second strobe it compares each setting with the current time. When every field that takes part in the comparison is equal, that alarm's flag is raised. Any field can be taken out of the comparison by setting bit 7 of its byte. With all four fields taken out, the alarm fires on every second.

Flags drive two active-low interrupt pins. Each alarm has its own interrupt enable. A steering bit chooses where alarm 1 goes: either to the second pin or merged onto the first pin. Software clears a flag in one of two ways: by writing a 0 to its status bit, or by reading any byte of that alarm's registers. The serial-port front end delivers register accesses as single-cycle read and write strobes with an address. The front end sends `reg_rdata` back to the host.

Top module: `alm_irq_comparator`

## Requirements
- R1: After reset, all alarm bytes read 0x00. The control and status registers read 0x00. Both `irq0_n` and `irq1_n` are high.
- R2: The alarm 0 bytes sit at addresses 0x07..0x0A and the alarm 1 bytes at 0x0B..0x0E, in the order seconds, minutes, hours, day of week. A write stores all 8 bits, and a read returns them unchanged.
- R3: A flag is set only in a cycle where `tick_1hz` is high and all included fields of that alarm equal the current time. Equal time with no strobe sets nothing.
- R4: Bit 7 set in an alarm byte removes that field from the comparison. With all four bytes marked this way, the flag sets on every strobe.
- R5: A field compares bits 6:0 of the alarm byte with bits 6:0 of the time byte as raw codes. For the hour field this includes the 12-hour mode bit (bit 6) and the PM bit (bit 5). So 0x52 does not match 0x12.
- R6: A read of any byte of an alarm clears only that alarm's flag, one cycle later. The read data shows the register contents. If the same cycle also brings a match on a strobe, the flag stays set.
- R7: A write to the status register (0x10) clears each flag whose data bit (bit 0 for alarm 0, bit 1 for alarm 1) is 0. A 1 leaves that flag unchanged and never sets it.
- R8: The control register (0x0F) has three bits: bit 0 enables the alarm 0 interrupt, bit 1 enables the alarm 1 interrupt, and bit 2 steers alarm 1. `irq0_n` is low exactly when (flag0 and bit 0) or (flag1 and bit 1 and bit 2 clear).
- R9: With control bit 2 set, `irq1_n` is low exactly when flag1 and bit 1 are both set. With bit 2 clear, `irq1_n` stays high.
- R10: The control register reads back its bits 2:0, with bits 7:3 as zero. The status register reads flag0 in bit 0 and flag1 in bit 1, with the upper bits zero. Reading the status register clears nothing.
- R11: Flags set whatever the enable bits are. Enabling an interrupt later, while its flag is set, pulls the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte (12/24-hour coding) |
| cur_wday | input | 8 | Current day-of-week byte |
| reg_addr | input | ADDR_W (5) | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq0_n | output | 1 | Interrupt pin 0, active low |
| irq1_n | output | 1 | Interrupt pin 1, active low |

## Verification
The hardest case to reach from the ports is a read of an alarm byte that lands in the same cycle as a strobe that matches again. Here the clear and the set compete for the same flag. The bench gets there by first making alarm 0 match on any time (all fields excluded). It then raises `reg_rd` and `tick_1hz` together on one falling edge, and after the edge expects the flag to still be set. A second hard case is the steering change while flag 1 is pending. The bench leaves the flag set and rewrites only the control register, which shows the same event moving from one pin to the other.

// File: rtl/alm_cmp_pkg.sv
package alm_cmp_pkg;

  localparam int NUM_ALARMS = 2;
  localparam int NUM_FIELDS = 4;
  localparam int BYTE_W     = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // Control register image: bit0 en0, bit1 en1, bit2 steer
  typedef struct packed {
    logic steer;
    logic en1;
    logic en0;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // A field takes part only when bit 7 is clear; compares raw bits 6:0
  function automatic logic field_hit(input byte_t alm, input byte_t cur);
    return alm[BYTE_W-1] || (alm[BYTE_W-2:0] == cur[BYTE_W-2:0]);
  endfunction

endpackage

// File: rtl/alm_field_bank.sv
module alm_field_bank
  import alm_cmp_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BASE   = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  byte_t                        wdata,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] cur_tod,
  output logic                         match,
  output logic                         all_dc,
  output logic                         sel,
  output byte_t                        rd_byte
);

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fld_q;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fld_d;
  logic [NUM_FIELDS-1:0]             fld_we;
  logic [NUM_FIELDS-1:0]             fld_hit;
  logic [NUM_FIELDS-1:0]             fld_sel;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(BASE + f);

    assign fld_sel[f] = (addr == FA);
    assign fld_we[f]  = wr_en && fld_sel[f];
    assign fld_hit[f] = field_hit(fld_q[f], cur_tod[f]);

    always_comb begin
      fld_d[f] = fld_q[f];
      if (fld_we[f]) fld_d[f] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q[f] <= '0;
      end else if (fld_we[f]) begin
        fld_q[f] <= fld_d[f];
      end
    end

    // R2: a write lands unchanged in the addressed field
    a_r2_field_stored: assert property (@(posedge clk) disable iff (!rst_n)
      fld_we[f] |=> (fld_q[f] == $past(wdata)));
  end

  always_comb begin
    rd_byte = '0;
    all_dc  = 1'b1;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (fld_sel[f]) rd_byte = rd_byte | fld_q[f];
      all_dc = all_dc & fld_q[f][BYTE_W-1];
    end
  end

  assign match = &fld_hit;
  assign sel   = |fld_sel;

endmodule

// File: rtl/alm_flag_ctrl.sv
module alm_flag_ctrl
  import alm_cmp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [NUM_ALARMS-1:0] match,
  input  logic [NUM_ALARMS-1:0] rd_clr,
  input  logic                  stat_wr,
  input  logic [NUM_ALARMS-1:0] stat_wdata,
  input  logic                  ctrl_wr,
  input  ctrl_t                 ctrl_wdata,
  output logic [NUM_ALARMS-1:0] flags,
  output ctrl_t                 ctrl,
  output logic                  irq0_n,
  output logic                  irq1_n
);

  logic [NUM_ALARMS-1:0] flag_q, flag_d;
  logic                  flag_ce;
  ctrl_t                 ctrl_q, ctrl_d;

  // next state
  always_comb begin
    flag_d = flag_q;
    for (int i = 0; i < NUM_ALARMS; i++) begin
      if (tick && match[i])                       flag_d[i] = 1'b1;
      else if (rd_clr[i] || (stat_wr && !stat_wdata[i])) flag_d[i] = 1'b0;
    end
  end

  assign flag_ce = tick || (|rd_clr) || stat_wr;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  // pin steering
  logic req0, req1;
  assign req0   = flag_q[0] && ctrl_q.en0;
  assign req1   = flag_q[1] && ctrl_q.en1;
  assign irq0_n = !(req0 || (req1 && !ctrl_q.steer));
  assign irq1_n = !(req1 && ctrl_q.steer);

  assign flags = flag_q;
  assign ctrl  = ctrl_q;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_chk
    // R3: a flag can only rise after a strobe
    a_r3_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(tick));
    // R6: a read clears the flag unless a matching strobe coincides
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr[i] && !(tick && match[i])) |=> !flag_q[i]);
  end

  // R7: a status write never raises a flag
  a_r7_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !tick) |=> ((flag_q & ~$past(flag_q)) == '0));

  // R9: pin 1 only ever asserts while steering is on
  a_r9_pin1_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
    !irq1_n |-> ctrl_q.steer);

endmodule

// File: rtl/alm_rd_mux.sv
module alm_rd_mux
  import alm_cmp_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 15,
  parameter int STAT_ADDR = 16
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_ALARMS-1:0]             bank_sel,
  input  logic [NUM_ALARMS-1:0][BYTE_W-1:0] bank_rdata,
  input  ctrl_t                             ctrl,
  input  logic [NUM_ALARMS-1:0]             flags,
  output byte_t                             rdata
);

  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_ADDR);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_ALARMS; i++) begin
      if (bank_sel[i]) rdata = rdata | bank_rdata[i];
    end
    if (addr == CA) rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
    if (addr == SA) rdata = {{(BYTE_W-NUM_ALARMS){1'b0}}, flags};
  end

endmodule

// File: rtl/alm_irq_comparator.sv
module alm_irq_comparator
  import alm_cmp_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ALM0_BASE = 7,
  parameter int ALM1_BASE = 11,
  parameter int CTRL_ADDR = 15,
  parameter int STAT_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_wday,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq0_n,
  output logic              irq1_n
);

  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAT_ADDR);

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] cur_tod;
  logic [NUM_ALARMS-1:0]             bank_match, bank_sel, bank_dc, rd_clr;
  logic [NUM_ALARMS-1:0][BYTE_W-1:0] bank_rdata;
  logic [NUM_ALARMS-1:0]             flags;
  ctrl_t                             ctrl;

  assign cur_tod = {cur_wday, cur_hour, cur_min, cur_sec};

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_bank
    localparam int B = (g == 0) ? ALM0_BASE : ALM1_BASE;
    alm_field_bank #(.ADDR_W(ADDR_W), .BASE(B)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .cur_tod (cur_tod),
      .match   (bank_match[g]),
      .all_dc  (bank_dc[g]),
      .sel     (bank_sel[g]),
      .rd_byte (bank_rdata[g])
    );
    assign rd_clr[g] = reg_rd && bank_sel[g];

    // R4: all fields excluded -> every strobe raises the flag
    a_r4_all_dc_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && bank_dc[g]) |=> flags[g]);
  end

  alm_flag_ctrl u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_1hz),
    .match      (bank_match),
    .rd_clr     (rd_clr),
    .stat_wr    (reg_wr && (reg_addr == SA)),
    .stat_wdata (reg_wdata[NUM_ALARMS-1:0]),
    .ctrl_wr    (reg_wr && (reg_addr == CA)),
    .ctrl_wdata (ctrl_t'(reg_wdata[CTRL_W-1:0])),
    .flags      (flags),
    .ctrl       (ctrl),
    .irq0_n     (irq0_n),
    .irq1_n     (irq1_n)
  );

  alm_rd_mux #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_rdmux (
    .addr       (reg_addr),
    .bank_sel   (bank_sel),
    .bank_rdata (bank_rdata),
    .ctrl       (ctrl),
    .flags      (flags),
    .rdata      (reg_rdata)
  );

  // R1: no pending flag means both pins idle
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (irq0_n && irq1_n));

endmodule

// File: tb/alm_irq_comparator_bench.sv
module alm_irq_comparator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  // {alarm s,m,h,w ; current s,m,h,w ; expected flag0}
  localparam logic [64:0] VECS [0:8] = '{
    {32'h30451203, 32'h30451203, 1'b1},  // R3 exact match
    {32'h30451203, 32'h31451203, 1'b0},  // R3 seconds differ
    {32'h80451203, 32'h59451203, 1'b1},  // R4 seconds excluded
    {32'h80808080, 32'h11223304, 1'b1},  // R4 all excluded
    {32'h00005201, 32'h00001201, 1'b0},  // R5 12h code vs 24h code
    {32'h00007201, 32'h00007201, 1'b1},  // R5 12h PM equal
    {32'h15808007, 32'h15010206, 1'b0},  // R3 weekday differs
    {32'h15808007, 32'h15010207, 1'b1},  // R4 min/hour excluded
    {32'h00000081, 32'h00000005, 1'b1}   // R4 weekday excluded
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_1hz;
  logic [7:0]    cur_sec, cur_min, cur_hour, cur_wday;
  logic [AW-1:0] reg_addr;
  logic          reg_wr, reg_rd;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          irq0_n, irq1_n;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alm_irq_comparator u_alm_irq_comparator (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq0_n(irq0_n), .irq1_n(irq1_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic set_time(input logic [31:0] t);
    {cur_sec, cur_min, cur_hour, cur_wday} = t;
  endtask

  task automatic pins(input string req, input logic [1:0] exp);
    #1 check(req, {6'b0, irq1_n, irq0_n}, {6'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0x01 expected 0x00");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; tick_1hz = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    set_time(32'h01020304);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    pins("R1 pins", 2'b11);
    rd(5'h0F, d); check("R1 ctrl", d, 8'h00);
    rd(5'h10, d); check("R1 status", d, 8'h00);
    rd(5'h09, d); check("R1 alarm0 hour", d, 8'h00);
    rd(5'h0E, d); check("R1 alarm1 wday", d, 8'h00);

    // vector table on alarm 0
    foreach (VECS[k]) begin
      for (int f = 0; f < 4; f++) wr(5'(7 + f), VECS[k][64-8*f -: 8]);
      set_time(VECS[k][32:1]);
      pulse_tick();
      rd(5'h10, d);
      check($sformatf("R3/R4/R5 vector %0d", k), d & 8'h01, {7'b0, VECS[k][0]});
      wr(5'h10, 8'h00);
    end

    // R2 alarm 1 layout and readback
    wr(5'h0B, 8'hA5); wr(5'h0C, 8'h3C); wr(5'h0D, 8'h52); wr(5'h0E, 8'h06);
    rd(5'h0B, d); check("R2 alm1 sec", d, 8'hA5);
    rd(5'h0C, d); check("R2 alm1 min", d, 8'h3C);
    rd(5'h0D, d); check("R2 alm1 hour", d, 8'h52);
    rd(5'h0E, d); check("R2 alm1 wday", d, 8'h06);
    rd(5'h07, d); check("R2 alm0 sec unchanged", d, 8'h00);

    // R3 equal time without strobe
    wr(5'h0B, 8'h25);
    set_time(32'h253C5206);
    repeat (4) @(negedge clk);
    rd(5'h10, d); check("R3 no tick no flag", d, 8'h00);

    // R11 flag with interrupts disabled
    pulse_tick();
    rd(5'h10, d); check("R11 flag1 while disabled", d, 8'h02);
    pins("R11 pins idle", 2'b11);
    wr(5'h0F, 8'h02);
    pins("R8 alm1 merged on pin0", 2'b10);
    wr(5'h0F, 8'h06);
    pins("R9 alm1 steered to pin1", 2'b01);
    wr(5'h0F, 8'hFF);
    rd(5'h0F, d); check("R10 ctrl readback", d, 8'h07);
    wr(5'h0F, 8'h06);

    // R7 status writes
    wr(5'h10, 8'h03);
    rd(5'h10, d); check("R7 ones keep flag", d, 8'h02);
    pins("R7 pin1 still low", 2'b01);
    wr(5'h10, 8'h01);
    rd(5'h10, d); check("R7 zero clears flag1", d, 8'h00);
    pins("R9 pin1 released", 2'b11);

    // R6 read clear per alarm
    for (int f = 0; f < 4; f++) wr(5'(7 + f), 8'h80);
    wr(5'h0F, 8'h07);
    pulse_tick();
    rd(5'h10, d); check("R6 both flags", d, 8'h03);
    pins("R8 alm0 on pin0", 2'b00);
    rd(5'h09, d); check("R6 read data", d, 8'h80);
    rd(5'h10, d); check("R6 only flag0 cleared", d, 8'h02);
    pins("R8 pin0 released", 2'b01);
    rd(5'h0E, d); check("R6 alm1 read data", d, 8'h06);
    rd(5'h10, d); check("R6 flag1 cleared", d, 8'h00);

    // R6 read and matching strobe together: set wins
    @(negedge clk);
    reg_addr = 5'h08; reg_rd = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; tick_1hz = 1'b0;
    rd(5'h10, d); check("R6 set wins over read", d, 8'h03);

    // R4 every second
    wr(5'h10, 8'h00);
    for (int s = 0; s < 3; s++) begin
      set_time({8'(s * 7), 24'h000000});
      pulse_tick();
      rd(5'h10, d); check("R4 fires every tick", d & 8'h01, 8'h01);
      rd(5'h07, d);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule